// File: doc/BRIEF.md
# Packed Floating-Point Predicate Comparator

This block compares single-precision IEEE-754 values held in two wide operands, lane by lane. Each operand carries four 32-bit lanes. A 3-bit predicate, taken from the low bits of an 8-bit immediate, selects one of eight relations. Four of these are ordered relations and four are their complements, which hold when either value is a NaN. Each lane answers with a full-width mask of ones or zeros. In scalar mode only the lowest lane is compared, and the upper lanes of the first operand flow through unchanged.

Alongside the mask, the block reports the relation of the lowest lane as a three-bit ordered-compare code of zero, parity and carry flags. In this code the unordered case is kept apart from greater, less and equal. Overflow, sign and auxiliary flags are reported as well and are always zero. Both the result and the flags are registered. They appear in the cycle after the strobe that carried the operands, and they hold their value until the next strobe.

Top module: `fpcmp_top`

## Requirements
- R1: While reset is high and in the first cycle after it, out_valid is 0, result is all zeros and cmp_flags is 000.
- R2: out_valid rises exactly one cycle after in_valid. Result and cmp_flags change only in the cycle after an accepted strobe and hold otherwise.
- R3: The predicate encodes as 0 equal, 1 less, 2 less-or-equal, 3 unordered, 4 not-equal, 5 not-less, 6 not-less-or-equal, 7 ordered.
- R4: Only imm[2:0] selects the predicate. imm[7:3] has no effect on result or flags.
- R5: Every compared lane yields 32'hFFFFFFFF when its predicate holds and 32'h00000000 when it does not.
- R6: When scalar_mode is 0, all four lanes are compared independently. Lane k occupies bits [32k+31:32k].
- R7: When scalar_mode is 1, only lane 0 is compared, and result bits [127:32] equal src_a bits [127:32].
- R8: A pair is unordered when either value has an all-ones exponent and a nonzero mantissa, whether quiet or signalling. For such a pair predicates 3, 4, 5 and 6 are true and predicates 0, 1, 2 and 7 are false.
- R9: Positive zero and negative zero compare equal.
- R10: cmp_flags = {zero, parity, carry} describes lane 0 in both modes: unordered 111, greater 000, less 001, equal 100.
- R11: aux_flags = {overflow, sign, auxiliary} is always 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand strobe |
| src_a | input | 128 | First operand, four single-precision lanes |
| src_b | input | 128 | Second operand, four single-precision lanes |
| imm | input | 8 | Immediate; the low 3 bits pick the predicate |
| scalar_mode | input | 1 | 1 = compare lane 0 only, 0 = compare all lanes |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| result | output | 128 | Registered per-lane masks |
| cmp_flags | output | 3 | Registered {zero, parity, carry} for lane 0 |
| aux_flags | output | 3 | {overflow, sign, auxiliary}, always zero |

## Verification
The hardest conditions to reach from the ports are exact ties and NaN pairs. Uniformly random 32-bit operands almost never produce equal values, signed-zero pairs or NaN encodings. The stimulus therefore draws each lane from a small pool of special encodings: both zeros, plus and minus one, both infinities, a quiet NaN and a signalling NaN. Only a few lanes get a fully random word. Because of this, equal, unordered and mixed-sign cases occur in every predicate and mode. The upper immediate bits are also randomised, and idle cycles are mixed in, so that the hold behaviour is observed at the result port.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;

    typedef enum logic [2:0] {
        PR_EQ    = 3'd0,
        PR_LT    = 3'd1,
        PR_LE    = 3'd2,
        PR_UNORD = 3'd3,
        PR_NE    = 3'd4,
        PR_NLT   = 3'd5,
        PR_NLE   = 3'd6,
        PR_ORD   = 3'd7
    } pred_e;

    // Relation of one lane pair; at most one of the three is set.
    typedef struct packed {
        logic unord;
        logic lt;
        logic eq;
    } rel_t;

    typedef struct packed {
        logic zf;
        logic pf;
        logic cf;
    } oflags_t;

    function automatic logic pred_eval(input pred_e p, input rel_t r);
        logic lt_o, eq_o;
        lt_o = r.lt & ~r.unord;
        eq_o = r.eq & ~r.unord;
        case (p)
            PR_EQ:    return eq_o;
            PR_LT:    return lt_o;
            PR_LE:    return lt_o | eq_o;
            PR_UNORD: return r.unord;
            PR_NE:    return ~eq_o;
            PR_NLT:   return ~lt_o;
            PR_NLE:   return ~(lt_o | eq_o);
            default:  return ~r.unord;
        endcase
    endfunction

    function automatic oflags_t flags_of(input rel_t r);
        oflags_t f;
        if (r.unord)   f = '{zf: 1'b1, pf: 1'b1, cf: 1'b1};
        else if (r.lt) f = '{zf: 1'b0, pf: 1'b0, cf: 1'b1};
        else if (r.eq) f = '{zf: 1'b1, pf: 1'b0, cf: 1'b0};
        else           f = '{zf: 1'b0, pf: 1'b0, cf: 1'b0};
        return f;
    endfunction

endpackage

// File: rtl/fpcmp_lane.sv
module fpcmp_lane #(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int W = 1 + EXP_W + MAN_W
) (
    input  logic [W-1:0]     op_a,
    input  logic [W-1:0]     op_b,
    output fpcmp_pkg::rel_t  rel
);
    logic             sign_a, sign_b;
    logic [W-2:0]     mag_a, mag_b;
    logic             nan_a, nan_b, any_nan;
    logic             both_zero, mag_lt, mag_eq;

    assign sign_a = op_a[W-1];
    assign sign_b = op_b[W-1];
    assign mag_a  = op_a[W-2:0];
    assign mag_b  = op_b[W-2:0];

    assign nan_a   = (&op_a[W-2 -: EXP_W]) & (|op_a[MAN_W-1:0]);
    assign nan_b   = (&op_b[W-2 -: EXP_W]) & (|op_b[MAN_W-1:0]);
    assign any_nan = nan_a | nan_b;

    assign both_zero = (mag_a == '0) && (mag_b == '0);
    assign mag_lt    = mag_a < mag_b;
    assign mag_eq    = mag_a == mag_b;

    always_comb begin
        rel.unord = any_nan;
        rel.eq    = ~any_nan & (both_zero | (op_a == op_b));
        if (any_nan || both_zero)
            rel.lt = 1'b0;
        else if (sign_a != sign_b)
            rel.lt = sign_a;
        else if (!sign_a)
            rel.lt = mag_lt;
        else
            rel.lt = ~mag_lt & ~mag_eq;
    end
endmodule

// File: rtl/fpcmp_pred.sv
module fpcmp_pred #(
    parameter int W = 32
) (
    input  fpcmp_pkg::pred_e pred,
    input  fpcmp_pkg::rel_t  rel,
    output logic [W-1:0]     mask
);
    logic hit;
    assign hit  = fpcmp_pkg::pred_eval(pred, rel);
    assign mask = {W{hit}};
endmodule

// File: rtl/fpcmp_top.sv
module fpcmp_top #(
    parameter int NUM_LANES = 4,
    parameter int EXP_W     = 8,
    parameter int MAN_W     = 23,
    parameter int IMM_W     = 8,
    localparam int LANE_W   = 1 + EXP_W + MAN_W,
    localparam int DATA_W   = NUM_LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [IMM_W-1:0]  imm,
    input  logic              scalar_mode,
    output logic              out_valid,
    output logic [DATA_W-1:0] result,
    output logic [2:0]        cmp_flags,
    output logic [2:0]        aux_flags
);
    import fpcmp_pkg::*;

    pred_e             pred;
    rel_t              lane_rel [NUM_LANES];
    logic [DATA_W-1:0] result_nxt;
    oflags_t           flags_nxt;

    assign pred = pred_e'(imm[2:0]);

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        logic [LANE_W-1:0] lane_mask;

        fpcmp_lane #(.EXP_W(EXP_W), .MAN_W(MAN_W)) cmp_i (
            .op_a (src_a[g*LANE_W +: LANE_W]),
            .op_b (src_b[g*LANE_W +: LANE_W]),
            .rel  (lane_rel[g])
        );

        fpcmp_pred #(.W(LANE_W)) dec_i (
            .pred (pred),
            .rel  (lane_rel[g]),
            .mask (lane_mask)
        );

        if (g == 0) begin : g_low
            assign result_nxt[g*LANE_W +: LANE_W] = lane_mask;
        end else begin : g_high
            assign result_nxt[g*LANE_W +: LANE_W] =
                scalar_mode ? src_a[g*LANE_W +: LANE_W] : lane_mask;
        end
    end

    assign flags_nxt = flags_of(lane_rel[0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            cmp_flags <= 3'b000;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result    <= result_nxt;
                cmp_flags <= flags_nxt;
            end
        end
    end

    assign aux_flags = 3'b000;
endmodule

// File: rtl/fpcmp_chk.sv
module fpcmp_chk #(
    parameter int NUM_LANES = 4,
    parameter int LANE_W    = 32,
    parameter int IMM_W     = 8,
    localparam int DATA_W   = NUM_LANES * LANE_W
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [DATA_W-1:0] src_a,
    input logic [IMM_W-1:0]  imm,
    input logic              scalar_mode,
    input logic              out_valid,
    input logic [DATA_W-1:0] result,
    input logic [2:0]        cmp_flags
);
    logic [2:0]        pred_q;
    logic              mode_q;
    logic [DATA_W-1:0] srca_q;
    logic              nan_true;

    always_ff @(posedge clk) begin
        if (rst) begin
            pred_q <= '0;
            mode_q <= 1'b0;
            srca_q <= '0;
        end else if (in_valid) begin
            pred_q <= imm[2:0];
            mode_q <= scalar_mode;
            srca_q <= src_a;
        end
    end

    assign nan_true = (pred_q == 3'd3) || (pred_q == 3'd4) ||
                      (pred_q == 3'd5) || (pred_q == 3'd6);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0 && cmp_flags == 3'b000))
        else $error("reset_clear_chk");

    // R2
    valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid)
        else $error("valid_lat_chk");

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result) && $stable(cmp_flags)))
        else $error("hold_chk");

    // R5
    low_mask_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (result[LANE_W-1:0] == '0 || result[LANE_W-1:0] == '1))
        else $error("low_mask_chk");

    for (genvar g = 1; g < NUM_LANES; g++) begin : g_up
        // R5
        up_mask_chk: assert property (@(posedge clk) disable iff (rst)
            (out_valid && !mode_q) |->
            (result[g*LANE_W +: LANE_W] == '0 || result[g*LANE_W +: LANE_W] == '1))
            else $error("up_mask_chk");

        // R7
        pass_thru_chk: assert property (@(posedge clk) disable iff (rst)
            (out_valid && mode_q) |->
            (result[g*LANE_W +: LANE_W] == srca_q[g*LANE_W +: LANE_W]))
            else $error("pass_thru_chk");
    end

    // R10
    flag_code_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (cmp_flags == 3'b111 || cmp_flags == 3'b000 ||
                       cmp_flags == 3'b001 || cmp_flags == 3'b100))
        else $error("flag_code_chk");

    // R8
    nan_pred_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && cmp_flags == 3'b111) |->
        (result[LANE_W-1:0] == (nan_true ? {LANE_W{1'b1}} : {LANE_W{1'b0}})))
        else $error("nan_pred_chk");
endmodule

bind fpcmp_top fpcmp_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .src_a       (src_a),
    .imm         (imm),
    .scalar_mode (scalar_mode),
    .out_valid   (out_valid),
    .result      (result),
    .cmp_flags   (cmp_flags)
);

// File: tb/fpcmp_top_tb_top.sv
`timescale 1ns/1ps
module fpcmp_top_tb_top;
    localparam real PERIOD = 8.0;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic [7:0]   imm = '0;
    logic         scalar_mode = 1'b0;
    logic         out_valid;
    logic [127:0] result;
    logic [2:0]   cmp_flags;
    logic [2:0]   aux_flags;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    model_on = 1'b0;
    bit    finished = 1'b0;
    string cur_req  = "R1";

    logic         m_valid;
    logic [127:0] m_res;
    logic [2:0]   m_flags;

    always #(PERIOD/2) clk = ~clk;

    fpcmp_top dut_i (
        .clk (clk), .rst (rst), .in_valid (in_valid),
        .src_a (src_a), .src_b (src_b), .imm (imm),
        .scalar_mode (scalar_mode), .out_valid (out_valid),
        .result (result), .cmp_flags (cmp_flags), .aux_flags (aux_flags)
    );

    // 0 greater, 1 less, 2 equal, 3 unordered
    function automatic int rel_of(input logic [31:0] a, input logic [31:0] b);
        longint ka, kb;
        bit na, nb;
        na = (a[30:23] == 8'hFF) && (a[22:0] != 0);
        nb = (b[30:23] == 8'hFF) && (b[22:0] != 0);
        if (na || nb) return 3;
        ka = a[31] ? -longint'(a[30:0]) : longint'(a[30:0]);
        kb = b[31] ? -longint'(b[30:0]) : longint'(b[30:0]);
        if (ka < kb) return 1;
        if (ka == kb) return 2;
        return 0;
    endfunction

    function automatic bit pred_ok(input int p, input int r);
        case (p)
            0: return r == 2;
            1: return r == 1;
            2: return r == 1 || r == 2;
            3: return r == 3;
            4: return r != 2;
            5: return r != 1;
            6: return !(r == 1 || r == 2);
            default: return r != 3;
        endcase
    endfunction

    function automatic logic [2:0] flags_ref(input int r);
        case (r)
            3: return 3'b111;
            1: return 3'b001;
            2: return 3'b100;
            default: return 3'b000;
        endcase
    endfunction

    function automatic logic [127:0] res_ref(input logic [127:0] a, input logic [127:0] b,
                                             input logic [7:0] im, input bit sc);
        logic [127:0] r;
        for (int k = 0; k < 4; k++) begin
            if (sc && k > 0)
                r[k*32 +: 32] = a[k*32 +: 32];
            else
                r[k*32 +: 32] = pred_ok(int'(im % 8), rel_of(a[k*32 +: 32], b[k*32 +: 32]))
                                ? 32'hFFFFFFFF : 32'h0;
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_valid <= 1'b0;
            m_res   <= '0;
            m_flags <= 3'b000;
        end else begin
            m_valid <= in_valid;
            if (in_valid) begin
                m_res   <= res_ref(src_a, src_b, imm, scalar_mode);
                m_flags <= flags_ref(rel_of(src_a[31:0], src_b[31:0]));
            end
        end
    end

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (model_on && !finished) begin
            check(cur_req, {out_valid, cmp_flags, aux_flags, result},
                           {m_valid, m_flags, 3'b000, m_res});
        end
    end

    task automatic drive(input logic [127:0] a, input logic [127:0] b,
                         input logic [7:0] im, input bit sc);
        @(negedge clk);
        src_a = a; src_b = b; imm = im; scalar_mode = sc; in_valid = 1'b1;
        @(posedge clk);
        #2;
        in_valid = 1'b0;
    endtask

    function automatic logic [31:0] pick_val();
        case ($urandom % 10)
            0: return 32'h00000000;
            1: return 32'h80000000;
            2: return 32'h3F800000;
            3: return 32'hBF800000;
            4: return 32'h7F800000;
            5: return 32'hFF800000;
            6: return 32'h7FC00000;
            7: return 32'h7F800001;
            8: return 32'h40000000;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        #(PERIOD * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        check("R1", {out_valid, cmp_flags, result}, '0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #2;
        check("R1", {out_valid, cmp_flags, result}, '0);
        model_on = 1'b1;

        // R9: -0 equals +0
        cur_req = "R9";
        drive({96'h0, 32'h80000000}, 128'h0, 8'h00, 1'b0);
        check("R9", {cmp_flags, result[31:0]}, {3'b100, 32'hFFFFFFFF});

        // R8: signalling NaN vs 1.0, not-equal is true, flags unordered
        cur_req = "R8";
        drive({96'h0, 32'h7F800001}, {96'h0, 32'h3F800000}, 8'h04, 1'b0);
        check("R8", {cmp_flags, result[31:0]}, {3'b111, 32'hFFFFFFFF});
        drive({96'h0, 32'h7FC00000}, {96'h0, 32'h3F800000}, 8'h00, 1'b0);
        check("R8", result[31:0], 32'h0);
        drive({96'h0, 32'h7FC00000}, {96'h0, 32'h3F800000}, 8'h07, 1'b0);
        check("R8", result[31:0], 32'h0);

        // R4: upper immediate bits ignored
        cur_req = "R4";
        drive({96'h0, 32'h3F800000}, {96'h0, 32'h40000000}, 8'hF9, 1'b0);
        check("R4", {cmp_flags, result[31:0]}, {3'b001, 32'hFFFFFFFF});
        drive({96'h0, 32'h3F800000}, {96'h0, 32'h40000000}, 8'hF8, 1'b0);
        check("R4", result[31:0], 32'h0);

        // R7: scalar pass-through of upper lanes
        cur_req = "R7";
        drive({32'hDEADBEEF, 32'h12345678, 32'hCAFEF00D, 32'h3F800000},
              {32'h0, 32'h0, 32'h0, 32'h3F800000}, 8'h00, 1'b1);
        check("R7", result, {32'hDEADBEEF, 32'h12345678, 32'hCAFEF00D, 32'hFFFFFFFF});

        // R6: independent lanes with less-than
        cur_req = "R6";
        drive({32'h3F800000, 32'h40000000, 32'hBF800000, 32'h7FC00000},
              {32'h40000000, 32'h40000000, 32'h3F800000, 32'h3F800000}, 8'h01, 1'b0);
        check("R6", result, {32'hFFFFFFFF, 32'h0, 32'hFFFFFFFF, 32'h0});
        check("R10", cmp_flags, 3'b111);

        // R10: greater-than code
        cur_req = "R10";
        drive({96'h0, 32'h40000000}, {96'h0, 32'h3F800000}, 8'h05, 1'b0);
        check("R10", cmp_flags, 3'b000);

        // R2: hold while idle
        cur_req = "R2";
        repeat (2) @(posedge clk);
        #2;
        check("R2", {out_valid, cmp_flags, result[31:0]}, {1'b0, 3'b000, 32'hFFFFFFFF});
        check("R11", aux_flags, 3'b000);

        // R3/R5/R6/R7/R8/R11: random sweep, compared every clock
        cur_req = "R3/R5/R6/R7/R8/R11";
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            in_valid = ($urandom % 4) != 0;
            for (int k = 0; k < 4; k++) begin
                src_a[k*32 +: 32] = pick_val();
                src_b[k*32 +: 32] = ($urandom % 4 == 0) ? src_a[k*32 +: 32] : pick_val();
            end
            imm = 8'($urandom);
            scalar_mode = ($urandom % 3) == 0;
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        #1;

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule